// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is the external bus master of a 32-bit embedded processor. It owns one shared 32-bit address/data bus. Each transaction opens with a single address cycle, in which bus bits 31:4 carry the address and the low nibble carries a code for the transfer size. One or more data beats follow. Two separate word-select outputs give the word within a four-word block, and during a cache-line refill they step through the block in sub-block order: the start word XORed with the beat number.

On the core side the block takes one request at a time: a word address, a byte count, a burst flag, a direction, write data and the port width of the target region. It returns read data with a last flag. A region may be 8, 16 or 32 bits wide. An access to a narrower region is split into sequential beats on the low byte lanes, and the block assembles or spreads the word for the core. Every data beat waits for an active-low ready input. After a read, a programmable number of idle cycles gives the bus time to turn around before the next address cycle.

Top module: `adbus_master`

## Requirements
- R1: After reset the strobe `ads_n` is 1, `ale` is 0, `ad_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: An accepted request gives exactly one address cycle, in which `ads_n` is 0, `ale` is 1, `ad_oe` is 1 and `ad_out[31:4]` equals `req_waddr[31:4]`. Outside that cycle `ale` is 0, and `ale` is always the inverse of `ads_n`.
- R3: In the address cycle `ad_out[3:0]` is 0000 for a burst. For a single transfer it is `req_bytes`+1, so 0001, 0010, 0011 and 0100 stand for 1, 2, 3 and 4 bytes (`req_bytes` 00..11). No other code is ever driven.
- R4: `wsel` equals `req_waddr[3:2]` in the address cycle and in the first data beat. In burst beat b (b = 0..3) it equals `req_waddr[3:2]` XOR b. For single transfers it stays constant.
- R5: A data beat completes only at a rising edge where `rdy_n` is 0. While `rdy_n` stays 1 the beat holds: `wsel` and the driven bus do not change.
- R6: A burst runs four 32-bit beats and returns one response per beat, with `rsp_last` set only on the fourth. A burst is always a read: `req_write` and `req_pw` have no effect on it.
- R7: A single transfer uses port width code 00 (8 bits) with `req_bytes`+1 beats, code 01 (16 bits) with `req_bytes[1]`+1 beats, and code 10 (32 bits) with one beat. A read takes beat k from lane 0 into byte k (8-bit) or halfword k (16-bit) of the result. Lanes not transferred read as zero, and one response with `rsp_last` = 1 is returned.
- R8: In write data beats `ad_oe` is 1 and `ad_out` equals `req_wdata` shifted right by 8·k (8-bit port), by 16·k (16-bit port) or by 0 (32-bit port) in beat k.
- R9: In read data beats, in turnaround and in idle cycles `ad_oe` is 0 and `ad_out` is all zeros.
- R10: When a request is waiting, the next address cycle starts `cfg_gap`+1 cycles after the cycle that follows the last read beat's ready edge, and 1 cycle after that cycle for a write.
- R11: Port width code 11 is treated as 32 bits.
- R12: A request is accepted only at an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only when no transaction is active and the turnaround count has expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_gap | input | GAP_W | Idle cycles after a read before the next address cycle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge if valid |
| req_waddr | input | 30 | Word address, bits 31:2 |
| req_bytes | input | 2 | Byte count minus one for single transfers |
| req_burst | input | 1 | Four-word block refill |
| req_write | input | 1 | 1 = write, 0 = read |
| req_pw | input | 2 | Region port width code |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Read word returned |
| rsp_data | output | 32 | Read word |
| rsp_last | output | 1 | Final response of the transaction |
| ad_out | output | 32 | Bus value driven |
| ad_oe | output | 1 | Bus output enable |
| ad_in | input | 32 | Bus value sampled |
| wsel | output | 2 | Word-within-block select |
| ads_n | output | 1 | Address strobe, active low |
| ale | output | 1 | Address latch enable |
| rdy_n | input | 1 | Beat ready, active low |

## Verification
A wrong beat counter or start-word register shows up at once on `wsel` at the next ready edge, and one response too many or too few follows in the same transaction. A wrong lane index shows as a corrupted byte or halfword in the single response at the end of a narrow read, or as a wrong `ad_out` value in the very write beat it drives. A turnaround counter that loads late or at the wrong value moves the next `ads_n` fall by one or more cycles. That shift is visible within `cfg_gap`+1 cycles of the last read beat.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BLK_WORDS = 4;
  localparam int unsigned BEAT_W    = $clog2(BLK_WORDS);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} bus_st_e;

  localparam logic [1:0] PW_8   = 2'b00;
  localparam logic [1:0] PW_16  = 2'b01;
  localparam logic [1:0] PW_32  = 2'b10;

  // Address-cycle nibble: 0000 block refill, else byte count code 1..4
  function automatic logic [3:0] size_code(input logic burst, input logic [1:0] nbytes_m1);
    return burst ? 4'b0000 : {2'b00, nbytes_m1} + 4'd1;
  endfunction

  function automatic logic [BEAT_W-1:0] final_beat(input logic burst, input logic [1:0] pw,
                                                   input logic [1:0] nbytes_m1);
    logic [BEAT_W-1:0] r;
    if (burst)            r = BEAT_W'(BLK_WORDS - 1);
    else if (pw == PW_8)  r = BEAT_W'(nbytes_m1);
    else if (pw == PW_16) r = BEAT_W'(nbytes_m1[1]);
    else                  r = '0;
    return r;
  endfunction
endpackage

// File: rtl/adbus_lane.sv
module adbus_lane
  import adbus_pkg::*;
(
  input  logic [1:0]        pw,
  input  logic [BEAT_W-1:0] wr_beat,
  input  logic [BEAT_W-1:0] rd_beat,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] asm_in,
  input  logic [WORD_W-1:0] bus_in,
  output logic [WORD_W-1:0] wr_lane,
  output logic [WORD_W-1:0] asm_out
);
  always_comb begin
    wr_lane = wdata;
    asm_out = asm_in;
    case (pw)
      PW_8: begin
        wr_lane = wdata >> {wr_beat, 3'b000};
        asm_out[{rd_beat, 3'b000} +: 8] = bus_in[7:0];
      end
      PW_16: begin
        wr_lane = wdata >> {wr_beat[0], 4'b0000};
        asm_out[{rd_beat[0], 4'b0000} +: 16] = bus_in[15:0];
      end
      default: asm_out = bus_in;
    endcase
  end
endmodule

// File: rtl/adbus_gap.sv
module adbus_gap #(
  parameter int unsigned GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  output logic             expired
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/adbus_seq.sv
module adbus_seq
  import adbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [31:2]       req_waddr,
  input  logic [1:0]        req_bytes,
  input  logic              req_burst,
  input  logic              req_write,
  input  logic [1:0]        req_pw,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              gap_expired,
  input  logic              rdy_n,
  input  logic [WORD_W-1:0] wr_lane,
  input  logic [WORD_W-1:0] asm_next,
  output logic              req_ready,
  output logic              gap_load,
  output logic [1:0]        pw_q,
  output logic [BEAT_W-1:0] wr_beat,
  output logic [BEAT_W-1:0] beat_q,
  output logic [WORD_W-1:0] wdata_q,
  output logic [WORD_W-1:0] asm_q,
  output logic [WORD_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ads_n,
  output logic              ale,
  output logic [1:0]        wsel,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_last
);
  bus_st_e           st_q;
  logic              burst_q, write_q;
  logic [1:0]        start_q;
  logic [BEAT_W-1:0] last_q;
  logic              beat_done, at_last;
  logic [BEAT_W-1:0] beat_inc;
  logic [1:0]        pw_eff;

  assign req_ready = (st_q == ST_IDLE) && gap_expired;
  assign beat_done = (st_q == ST_DATA) && !rdy_n;
  assign at_last   = (beat_q == last_q);
  assign beat_inc  = beat_q + 1'b1;
  assign wr_beat   = (st_q == ST_DATA) ? beat_inc : '0;
  assign gap_load  = beat_done && at_last && !write_q;
  assign pw_eff    = (req_burst || req_pw == 2'b11) ? PW_32 : req_pw;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;  ads_n <= 1'b1;  ale <= 1'b0;  ad_oe <= 1'b0;
      ad_out <= '0;     wsel <= '0;     start_q <= '0;
      burst_q <= 1'b0;  write_q <= 1'b0; pw_q <= PW_32;
      wdata_q <= '0;    asm_q <= '0;    beat_q <= '0;  last_q <= '0;
      rsp_valid <= 1'b0; rsp_last <= 1'b0; rsp_data <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid && req_ready) begin
          st_q    <= ST_ADDR;
          ads_n   <= 1'b0;
          ale     <= 1'b1;
          ad_oe   <= 1'b1;
          ad_out  <= {req_waddr[31:4], size_code(req_burst, req_bytes)};
          wsel    <= req_waddr[3:2];
          start_q <= req_waddr[3:2];
          burst_q <= req_burst;
          write_q <= req_write && !req_burst;
          pw_q    <= pw_eff;
          wdata_q <= req_wdata;
          asm_q   <= '0;
          beat_q  <= '0;
          last_q  <= final_beat(req_burst, pw_eff, req_bytes);
        end
        ST_ADDR: begin
          st_q   <= ST_DATA;
          ads_n  <= 1'b1;
          ale    <= 1'b0;
          ad_oe  <= write_q;
          ad_out <= write_q ? wr_lane : '0;
        end
        default: if (beat_done) begin
          if (!write_q) begin
            asm_q <= asm_next;
            if (burst_q || at_last) begin
              rsp_valid <= 1'b1;
              rsp_data  <= asm_next;
              rsp_last  <= at_last;
            end
          end
          if (at_last) begin
            st_q   <= ST_IDLE;
            ad_oe  <= 1'b0;
            ad_out <= '0;
          end else begin
            beat_q <= beat_inc;
            if (burst_q) wsel <= start_q ^ 2'(beat_inc);
            ad_out <= write_q ? wr_lane : '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adbus_master.sv
module adbus_master
  import adbus_pkg::*;
#(
  parameter int unsigned GAP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:2]       req_waddr,
  input  logic [1:0]        req_bytes,
  input  logic              req_burst,
  input  logic              req_write,
  input  logic [1:0]        req_pw,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_last,
  output logic [WORD_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [WORD_W-1:0] ad_in,
  output logic [1:0]        wsel,
  output logic              ads_n,
  output logic              ale,
  input  logic              rdy_n
);
  logic              gap_expired, gap_load;
  logic [1:0]        pw_q;
  logic [BEAT_W-1:0] wr_beat, beat_q;
  logic [WORD_W-1:0] wdata_q, asm_q, wr_lane, asm_next;

  adbus_seq u_seq (
    .clk, .rst, .req_valid, .req_waddr, .req_bytes, .req_burst, .req_write,
    .req_pw, .req_wdata, .gap_expired, .rdy_n, .wr_lane, .asm_next,
    .req_ready, .gap_load, .pw_q, .wr_beat, .beat_q, .wdata_q, .asm_q,
    .ad_out, .ad_oe, .ads_n, .ale, .wsel, .rsp_valid, .rsp_data, .rsp_last
  );

  adbus_lane u_lane (
    .pw(pw_q), .wr_beat, .rd_beat(beat_q), .wdata(wdata_q),
    .asm_in(asm_q), .bus_in(ad_in), .wr_lane, .asm_out(asm_next)
  );

  adbus_gap #(.GAP_W(GAP_W)) u_gap (
    .clk, .rst, .load(gap_load), .load_val(cfg_gap), .expired(gap_expired)
  );
endmodule

// File: rtl/adbus_master_chk.sv
module adbus_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] ad_out,
  input logic        ad_oe,
  input logic [1:0]  wsel,
  input logic        ads_n,
  input logic        ale,
  input logic        rdy_n,
  input logic        rsp_valid
);
  // R2: latch enable mirrors the strobe
  a_r2_ale_inverse: assert property (@(posedge clk) disable iff (rst) ale != ads_n);
  // R2: address cycle lasts one cycle
  a_r2_addr_single: assert property (@(posedge clk) disable iff (rst) !ads_n |=> ads_n);
  // R3: only legal size codes in the address cycle
  a_r3_size_legal: assert property (@(posedge clk) disable iff (rst)
    !ads_n |-> (ad_out[3:0] <= 4'd4));
  // R4: first data beat keeps the address-cycle word select
  a_r4_first_wsel: assert property (@(posedge clk) disable iff (rst) !ads_n |=> $stable(wsel));
  // R5: a response only follows a ready edge
  a_r5_rsp_after_ready: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(!rdy_n));
  // R9: bus released and quiet after a read beat, zero whenever released
  a_r9_read_released: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> !ad_oe);
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst) !ad_oe |-> (ad_out == '0));
  // R12: an accepted request opens an address cycle
  a_r12_accept_starts: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!ads_n && ad_oe));
endmodule

bind adbus_master adbus_master_chk u_chk (.*);

// File: tb/adbus_master_test.sv
module adbus_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int GAP_W = 4;
  localparam int WDOG = 20000;

  typedef struct {
    logic [31:0] addr; logic [3:0] code; int nb; logic wr; logic burst;
    logic [1:0] pw; logic [31:0] wdata;
  } addr_item_t;
  typedef struct { logic [31:0] data; logic last; string tag; } rsp_item_t;

  logic clk = 0, rst = 1;
  logic [GAP_W-1:0] cfg_gap = '0;
  logic req_valid = 0, req_burst = 0, req_write = 0;
  logic [31:2] req_waddr = '0;
  logic [1:0] req_bytes = '0, req_pw = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_last, ad_oe, ads_n, ale;
  logic [31:0] rsp_data, ad_out;
  logic [31:0] ad_in = '0;
  logic [1:0] wsel;
  logic rdy_n = 1;

  int checks = 0, fails = 0, waits = 0;
  bit done = 0;
  addr_item_t exp_addr[$];
  rsp_item_t  exp_rsp[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adbus_master #(.GAP_W(GAP_W)) uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] a, input logic [1:0] w, input int k);
    return ((a & 32'hFFFF_FFF0) ^ {w, k[1:0], 28'h0}) * 32'h9E37_79B1 + {28'h0, w, k[1:0]};
  endfunction

  task automatic issue(input logic [31:0] a, input logic [1:0] nbm1, input logic bst,
                       input logic wr, input logic [1:0] pw, input logic [31:0] wd);
    addr_item_t it;
    logic [1:0] epw;
    logic [31:0] asm;
    epw = (bst || pw == 2'b11) ? 2'b10 : pw;
    it.addr = a; it.burst = bst; it.wr = wr && !bst; it.pw = epw; it.wdata = wd;
    it.code = bst ? 4'b0000 : {2'b00, nbm1} + 4'd1;
    it.nb = bst ? 4 : (epw == 2'b00) ? int'(nbm1) + 1 : (epw == 2'b01) ? int'(nbm1[1]) + 1 : 1;
    exp_addr.push_back(it);
    if (!it.wr) begin
      if (bst) begin
        for (int b = 0; b < 4; b++)
          exp_rsp.push_back('{pat(a, a[3:2] ^ 2'(b), b), b == 3, "R6"});
      end else begin
        asm = '0;
        for (int k = 0; k < it.nb; k++) begin
          if (epw == 2'b00)      asm[8*k +: 8]   = pat(a, a[3:2], k)[7:0];
          else if (epw == 2'b01) asm[16*k +: 16] = pat(a, a[3:2], k)[15:0];
          else                   asm = pat(a, a[3:2], k);
        end
        exp_rsp.push_back('{asm, 1'b1, (pw == 2'b11) ? "R11" : "R7"});
      end
    end
    @(negedge clk);
    req_waddr = a[31:2]; req_bytes = nbm1; req_burst = bst; req_write = wr;
    req_pw = pw; req_wdata = wd; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  // Bus slave: ready generation, address/data checks, turnaround timing
  initial begin
    addr_item_t cur;
    bit indata = 0, armed = 0;
    int beat = 0, wcnt = 0, gcnt = 0, gexp = 0;
    logic [1:0] ew;
    logic [31:0] ewd;
    forever begin
      @(negedge clk);
      if (rst) continue;
      if (armed && ads_n) gcnt++;
      if (indata && !rdy_n) begin
        beat++; rdy_n = 1; wcnt = waits;
        if (beat == cur.nb) begin
          indata = 0;
          if (req_valid) begin armed = 1; gcnt = 0; gexp = cur.wr ? 1 : int'(cfg_gap) + 1; end
        end
      end
      if (!ads_n) begin
        if (armed) chk(gcnt + 1 == gexp, "R10 turnaround", gcnt + 1, gexp);
        armed = 0;
        if (exp_addr.size() == 0) chk(0, "R2 unexpected address", ad_out, 0);
        else begin
          cur = exp_addr.pop_front();
          chk(ad_out[31:4] == cur.addr[31:4], "R2 address", ad_out, cur.addr);
          chk(ale && ad_oe, "R2 ale/oe", {ale, ad_oe}, 2'b11);
          chk(ad_out[3:0] == cur.code, "R3 size code", ad_out[3:0], cur.code);
          chk(wsel == cur.addr[3:2], "R4 start word", wsel, cur.addr[3:2]);
          chk(!req_ready, "R12 busy", req_ready, 0);
          indata = 1; beat = 0; wcnt = waits;
        end
      end else if (indata) begin
        ew  = cur.burst ? cur.addr[3:2] ^ 2'(beat) : cur.addr[3:2];
        ewd = (cur.pw == 2'b00) ? cur.wdata >> (8*beat) :
              (cur.pw == 2'b01) ? cur.wdata >> (16*beat) : cur.wdata;
        if (wcnt > 0) begin
          wcnt--;
          chk(wsel == ew && ad_oe == cur.wr && ale == 0, "R5 hold in wait", wsel, ew);
        end else begin
          chk(wsel == ew, "R4 beat word", wsel, ew);
          if (cur.wr) chk(ad_oe && ad_out == ewd, "R8 write lane", ad_out, ewd);
          else        chk(!ad_oe && ad_out == 0, "R9 released", {31'h0, ad_oe}, 0);
          ad_in = pat(cur.addr, ew, beat);
          rdy_n = 0;
        end
      end
    end
  end

  // Response monitor / scoreboard
  initial begin
    rsp_item_t e;
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        if (exp_rsp.size() == 0) chk(0, "R6 unexpected response", rsp_data, 0);
        else begin
          e = exp_rsp.pop_front();
          chk(rsp_data == e.data, e.tag, rsp_data, e.data);
          chk(rsp_last == e.last, {e.tag, " last"}, rsp_last, e.last);
        end
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected 0 cycles left", WDOG);
      summary();
    end
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(ads_n && !ale && !ad_oe && !rsp_valid && req_ready, "R1 reset state",
        {ads_n, ale, ad_oe, rsp_valid, req_ready}, 5'b10001);
    cfg_gap = 2; waits = 0;
    issue(32'h1000_0100, 2'd3, 0, 0, 2'b10, 0);          // R7 32-bit read
    issue(32'h2000_0208, 2'd0, 1, 0, 2'b10, 0);          // R6 burst, start word 2
    waits = 1;
    issue(32'h2000_0304, 2'd0, 1, 0, 2'b00, 0);          // R6 burst start 1, pw ignored, R5 waits
    cfg_gap = 0; waits = 0;
    issue(32'h2000_040C, 2'd0, 1, 1, 2'b01, 32'hFFFF);   // R6 write flag ignored
    issue(32'h3000_0000, 2'd3, 0, 0, 2'b00, 0);          // R7 four byte beats
    cfg_gap = 5;
    issue(32'h3000_0010, 2'd1, 0, 0, 2'b00, 0);          // R7 two byte beats
    issue(32'h3000_0020, 2'd2, 0, 0, 2'b01, 0);          // R7 16-bit, 2 beats
    waits = 2;
    issue(32'h4000_0040, 2'd3, 0, 1, 2'b10, 32'hCAFE_F00D); // R8 32-bit write
    issue(32'h4000_0044, 2'd3, 0, 1, 2'b00, 32'h1234_5678); // R8 byte write
    issue(32'h4000_0048, 2'd3, 0, 1, 2'b01, 32'h9ABC_DEF0); // R8 halfword write
    cfg_gap = 1; waits = 0;
    issue(32'h5000_0050, 2'd3, 0, 0, 2'b11, 0);          // R11 reserved width
    s = 32'h1357_9BDF;
    for (int i = 0; i < 24; i++) begin
      s = s * 32'h0019_660D + 32'h3C6E_F35F;
      cfg_gap = GAP_W'(s[3:2]);
      waits = int'(s[5:4]) % 3;
      issue({s[31:4], s[9:8], 2'b00}, s[11:10], s[12] & s[13], s[14], s[16:15], s ^ 32'hA5A5_5A5A);
    end
    repeat (40) @(negedge clk);
    chk(exp_rsp.size() == 0 && exp_addr.size() == 0, "R6 all items seen",
        exp_rsp.size() + exp_addr.size(), 0);
    chk(req_ready && ads_n && !ad_oe, "R12 idle ready", {req_ready, ads_n, ad_oe}, 3'b110);
    done = 1;
    summary();
  end
endmodule